// File: doc/BRIEF.md
# Software-Clocked Serial EEPROM Read Responder

This block stands in for a small serial EEPROM of 64 sixteen-bit words behind a pair of host registers. Software has no real serial link. It toggles a clock, a select and a data-in line by writing a pin register, one write per step. It reads the same register to see the pins it last wrote, a data-out line and two status bits that are always set. The responder follows the classic three-wire read protocol on those software-made edges. Nine bits are shifted in: a three-bit opcode and then a six-bit word address. After that, data leaves the device most significant bit first, one bit per falling clock edge. Words keep streaming past the first one and wrap from the last word back to word 0.

A second register skips the serial protocol. Software writes a word address there and reads the word back at once, with a done flag set. The storage is preloaded from parameters: a seed pattern fills the words, and the last word is a checksum word. Write and erase commands are not supported.

Top module: `uwire_eeprom`

## Requirements
- R1: After reset the pin register reads 0x0000_0068: pins low, data-out high, status bits set. The direct register reads address 0 with done set, i.e. {word0, 16'h0010}.
- R2: Pin register read layout: bit0 clock, bit1 select, bit2 data-in and bit4 request, all as last written. Bit3 is data-out, and bit5 and bit6 are status bits that always read 1. All other bits read 0, and the values written to bits 3, 5, 6 and 7 and above are dropped.
- R3: A pin-register write whose clock bit equals the stored clock bit updates only the stored pins. The output pointer, the reading flag, the shift register and the bit counter keep their values.
- R4: Each falling clock edge (stored 1, written 0) advances the output bit pointer by one, modulo 1024.
- R5: A rising clock edge with select written 0 clears the shift register, the bit counter, the output pointer and the reading flag, so data-out reads 1.
- R6: A rising clock edge with select written 1 shifts data-in into the shift register LSB and counts the bit. When the count reaches 9 and no read is active, bits [8:6] are decoded as the opcode and bits [5:0] as the word address, using the bit shifted in on that same edge. Only opcode 3'b110 starts a read, and it loads the pointer with address*16-1, modulo 1024.
- R7: Data-out is 1 while no read is active. During a read it is bit (15 - ptr[3:0]) of word ptr[9:4]. The first falling edge after the decode therefore gives the MSB of the addressed word, later words follow in order, and word 63 is followed by word 0.
- R8: A direct-register write keeps bits [15:8] as the address and drops every other bit. A read returns {data, address, 8'h10}, so bit4 (done) reads 1 and bit0 (start) reads 0.
- R9: A direct-register address above 63 returns a data field of 0.
- R10: Word i (i < 63) holds SEED + i*16'h0111 modulo 2^16, with SEED = 16'h1357 by default. Word 63 makes the 16-bit sum of all 64 words equal SUM_TARGET = 16'hBABA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 pin register, 1 direct-read register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the register chosen by reg_addr (combinational) |

## Verification
Two things can happen on the same register write. The ninth rising edge both shifts in the last address bit and decodes the command. The bench reads an odd address (word 5), so an address decoded from the shift register before its update would stream the wrong word; the streamed bits are compared with the computed word 5 and then word 6. The serial stream and the direct register also read the shared storage in the same cycle. The bench interleaves direct reads between serial bits and checks that neither disturbs the other.

// File: rtl/uwire_pkg.sv
// uwire_pkg: shared constants for the software-clocked EEPROM responder.
// Assumes a 3-bit opcode followed by the word address in the command.
package uwire_pkg;
    localparam int          WORD_W   = 16;
    localparam int          OP_W     = 3;
    localparam logic [2:0]  OP_READ  = 3'b110;

    // Pin register bit positions
    localparam int PIN_SK   = 0;
    localparam int PIN_CS   = 1;
    localparam int PIN_DI   = 2;
    localparam int PIN_DO   = 3;
    localparam int PIN_REQ  = 4;
    localparam int PIN_GNT  = 5;
    localparam int PIN_PRES = 6;

    // Direct register field positions
    localparam int DIR_DONE = 4;
    localparam int DIR_ADDR = 8;
    localparam int DIR_DATA = 16;

    // Seed pattern for one preloaded word
    function automatic logic [WORD_W-1:0] seed_word(input int idx, input logic [WORD_W-1:0] seed);
        return seed + WORD_W'(idx) * 16'h0111;
    endfunction
endpackage

// File: rtl/uwire_rom.sv
// uwire_rom: preloaded word storage with two combinational read ports.
// Assumes the last word is a checksum so that all words sum to SUM_TARGET.
module uwire_rom
    import uwire_pkg::*;
#(
    parameter int          ADDR_W     = 6,
    parameter logic [15:0] SEED       = 16'h1357,
    parameter logic [15:0] SUM_TARGET = 16'hBABA
) (
    input  logic [ADDR_W-1:0] a_idx,
    output logic [WORD_W-1:0] a_word,
    input  logic [ADDR_W-1:0] b_idx,
    output logic [WORD_W-1:0] b_word
);
    localparam int WORDS = 1 << ADDR_W;

    // Sum of every word except the checksum word
    function automatic logic [WORD_W-1:0] partial_sum();
        logic [WORD_W-1:0] s = '0;
        for (int k = 0; k < WORDS - 1; k++) s = s + seed_word(k, SEED);
        return s;
    endfunction

    logic [WORD_W-1:0] mem [WORDS];

    // Fill storage from the seed, checksum word last
    generate
        for (genvar i = 0; i < WORDS; i++) begin : g_word
            if (i == WORDS - 1) begin : g_sum
                assign mem[i] = SUM_TARGET - partial_sum();
            end else begin : g_seed
                assign mem[i] = seed_word(i, SEED);
            end
        end
    endgenerate

    assign a_word = mem[a_idx];
    assign b_word = mem[b_idx];
endmodule

// File: rtl/uwire_serial.sv
// uwire_serial: serial read engine advanced only by host writes of the pins.
// Assumes a clock edge is a change of the written clock bit against the stored one.
module uwire_serial
    import uwire_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int PTR_W = ADDR_W + 4,
    localparam int CMD_BITS = OP_W + ADDR_W,
    localparam int CNT_W = $clog2(CMD_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sk_in,
    input  logic              cs_in,
    input  logic              di_in,
    input  logic              req_in,
    input  logic [WORD_W-1:0] word_in,
    output logic [ADDR_W-1:0] word_idx,
    output logic [6:0]        pin_view,
    output logic              sk_q,
    output logic [PTR_W-1:0]  ptr,
    output logic              reading,
    output logic [CNT_W-1:0]  bitcnt
);
    logic                cs_q, di_q, req_q;
    logic [CMD_BITS-1:0] shreg;
    logic [CMD_BITS-1:0] sh_nx;
    logic [CNT_W-1:0]    cnt_nx;
    logic                dout;

    // Next shift value and count for a rising edge with select high
    always_comb begin
        sh_nx  = {shreg[CMD_BITS-2:0], di_in};
        cnt_nx = bitcnt + 1'b1;
    end

    // Pin storage and serial state update on host writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {sk_q, cs_q, di_q, req_q} <= '0;
            shreg   <= '0;
            bitcnt  <= '0;
            ptr     <= '0;
            reading <= 1'b0;
        end else if (wr_en) begin
            {sk_q, cs_q, di_q, req_q} <= {sk_in, cs_in, di_in, req_in};
            if (sk_in != sk_q) begin
                if (!sk_in) begin
                    ptr <= ptr + 1'b1;
                end else if (!cs_in) begin
                    shreg   <= '0;
                    bitcnt  <= '0;
                    ptr     <= '0;
                    reading <= 1'b0;
                end else begin
                    shreg <= sh_nx;
                    if (bitcnt != {CNT_W{1'b1}}) bitcnt <= cnt_nx;
                    if (cnt_nx == CNT_W'(CMD_BITS) && !reading) begin
                        ptr     <= {sh_nx[ADDR_W-1:0], 4'b0000} - 1'b1;
                        reading <= (sh_nx[CMD_BITS-1 -: OP_W] == OP_READ);
                    end
                end
            end
        end
    end

    // Data-out selection, MSB first within the pointed word
    always_comb begin
        word_idx = ptr[PTR_W-1:4];
        dout     = !reading | word_in[~ptr[3:0]];
        pin_view = '0;
        pin_view[PIN_SK]   = sk_q;
        pin_view[PIN_CS]   = cs_q;
        pin_view[PIN_DI]   = di_q;
        pin_view[PIN_DO]   = dout;
        pin_view[PIN_REQ]  = req_q;
        pin_view[PIN_GNT]  = 1'b1;
        pin_view[PIN_PRES] = 1'b1;
    end
endmodule

// File: rtl/uwire_direct.sv
// uwire_direct: direct word read register, completes in zero cycles.
// Assumes addresses above the last word return an empty data field.
module uwire_direct
    import uwire_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int FLD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FLD_W-1:0]  addr_in,
    input  logic [WORD_W-1:0] word_in,
    output logic [ADDR_W-1:0] word_idx,
    output logic [31:0]       view
);
    localparam int WORDS = 1 << ADDR_W;

    logic [FLD_W-1:0] addr_q;

    // Hold the written address field
    always_ff @(posedge clk) begin
        if (!rst_n)     addr_q <= '0;
        else if (wr_en) addr_q <= addr_in;
    end

    // Assemble the read view: data, address, done
    always_comb begin
        word_idx = addr_q[ADDR_W-1:0];
        view     = '0;
        view[DIR_DONE] = 1'b1;
        view[DIR_ADDR +: FLD_W] = addr_q;
        view[DIR_DATA +: WORD_W] = (32'(addr_q) < WORDS) ? word_in : '0;
    end
endmodule

// File: rtl/uwire_eeprom.sv
// uwire_eeprom: top of the software-clocked serial EEPROM responder.
// Assumes register reads have no side effects; reg_rdata follows reg_addr.
module uwire_eeprom
    import uwire_pkg::*;
#(
    parameter int          ADDR_W     = 6,
    parameter logic [15:0] SEED       = 16'h1357,
    parameter logic [15:0] SUM_TARGET = 16'hBABA,
    localparam int PTR_W = ADDR_W + 4,
    localparam int CNT_W = $clog2(OP_W + ADDR_W + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    logic [ADDR_W-1:0] ser_idx, dir_idx;
    logic [WORD_W-1:0] ser_word, dir_word;
    logic [6:0]        pin_view;
    logic [31:0]       dir_view;
    logic              sk_q, reading;
    logic [PTR_W-1:0]  ptr;
    logic [CNT_W-1:0]  bitcnt;
    logic              unused_wdata;

    assign unused_wdata = ^{reg_wdata[31:16], reg_wdata[7:5], reg_wdata[3]};

    uwire_rom #(.ADDR_W(ADDR_W), .SEED(SEED), .SUM_TARGET(SUM_TARGET)) u_rom (
        .a_idx (ser_idx), .a_word (ser_word),
        .b_idx (dir_idx), .b_word (dir_word)
    );

    uwire_serial #(.ADDR_W(ADDR_W)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr && !reg_addr),
        .sk_in    (reg_wdata[PIN_SK]),
        .cs_in    (reg_wdata[PIN_CS]),
        .di_in    (reg_wdata[PIN_DI]),
        .req_in   (reg_wdata[PIN_REQ]),
        .word_in  (ser_word),
        .word_idx (ser_idx),
        .pin_view (pin_view),
        .sk_q     (sk_q),
        .ptr      (ptr),
        .reading  (reading),
        .bitcnt   (bitcnt)
    );

    uwire_direct #(.ADDR_W(ADDR_W), .FLD_W(8)) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr && reg_addr),
        .addr_in  (reg_wdata[DIR_ADDR +: 8]),
        .word_in  (dir_word),
        .word_idx (dir_idx),
        .view     (dir_view)
    );

    // Read mux between the two registers
    always_comb begin
        reg_rdata = reg_addr ? dir_view : {25'd0, pin_view};
    end
endmodule

// File: rtl/uwire_eeprom_chk.sv
// uwire_eeprom_chk: protocol checks bound to uwire_eeprom.
// Assumes the bound signals are the engine's stored state.
module uwire_eeprom_chk #(
    parameter int PTR_W = 10,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic             sk_q,
    input logic [PTR_W-1:0] ptr,
    input logic             reading,
    input logic [CNT_W-1:0] bitcnt
);
    logic pin_wr;
    assign pin_wr = reg_wr && !reg_addr;

    AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_addr |-> (reg_rdata[6:5] == 2'b11 && reg_rdata[31:7] == '0)); // R2

    AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(pin_wr && reg_wdata[0] != sk_q) |=> ($stable(ptr) && $stable(reading) && $stable(bitcnt))); // R3

    AST_FALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_wr && sk_q && !reg_wdata[0]) |=> (ptr == PTR_W'($past(ptr) + 1'b1))); // R4

    AST_DESELECT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_wr && !sk_q && reg_wdata[0] && !reg_wdata[1]) |=> (bitcnt == '0 && !reading && ptr == '0)); // R5

    AST_IDLE_DOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!reading && !reg_addr) |-> reg_rdata[3]); // R7

    AST_DIRECT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr |-> (reg_rdata[4] && !reg_rdata[0])); // R8
endmodule

bind uwire_eeprom uwire_eeprom_chk #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .sk_q      (sk_q),
    .ptr       (ptr),
    .reading   (reading),
    .bitcnt    (bitcnt)
);

// File: tb/tb_uwire_eeprom.sv
module tb_uwire_eeprom;
    localparam time CLK_P = 20ns;
    localparam logic [15:0] SEED = 16'h1357;
    localparam logic [15:0] SUMT = 16'hBABA;

    // {write value, expected readback} for pin-register walk (R2, R3)
    localparam logic [63:0] PIN_VEC [8] = '{
        {32'h0000_00FF, 32'h0000_007F},
        {32'hFFFF_FF00, 32'h0000_0068},
        {32'h0000_0013, 32'h0000_007B},
        {32'h0000_0006, 32'h0000_006E},
        {32'h0000_0001, 32'h0000_0069},
        {32'h0000_0010, 32'h0000_0078},
        {32'h0000_0002, 32'h0000_006A},
        {32'h0000_0000, 32'h0000_0068}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    uwire_eeprom dut (.*);

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [15:0] model(input int i);
        logic [15:0] s = '0;
        if (i < 63) return SEED + 16'(i) * 16'h0111;
        for (int k = 0; k < 63; k++) s = s + SEED + 16'(k) * 16'h0111;
        return SUMT - s;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic pins(input logic cs, input logic di, input logic sk);
        wr(1'b0, {29'd0, di, cs, sk});
    endtask

    // Deselect reset, then shift the nine command bits
    task automatic send_cmd(input logic [2:0] op, input logic [5:0] a);
        logic [8:0] cmd;
        cmd = {op, a};
        pins(1'b0, 1'b0, 1'b0);
        pins(1'b0, 1'b0, 1'b1);
        for (int i = 8; i >= 0; i--) begin
            pins(1'b1, cmd[i], 1'b0);
            pins(1'b1, cmd[i], 1'b1);
        end
    endtask

    task automatic get_word(output logic [15:0] w);
        logic [31:0] v;
        for (int b = 0; b < 16; b++) begin
            pins(1'b1, 1'b0, 1'b0);
            rd(1'b0, v);
            w[15-b] = v[3];
            pins(1'b1, 1'b0, 1'b1);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [15:0] w;
        logic [15:0] sum;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, v); check("R1 pin reg", v, 32'h0000_0068);
        rd(1'b1, v); check("R1 direct reg", v, {model(0), 16'h0010});

        // R2 R3 pin-register vector walk
        for (int i = 0; i < 8; i++) begin
            wr(1'b0, PIN_VEC[i][63:32]);
            rd(1'b0, v);
            check("R2 pin readback", v, PIN_VEC[i][31:0]);
        end

        // R6 R7 read odd address, stream into next word
        send_cmd(3'b110, 6'd5);
        get_word(w); check("R6 word 5", {16'd0, w}, {16'd0, model(5)});
        wr(1'b1, 32'h0000_1100);
        rd(1'b1, v); check("R8 direct during stream", v, {model(17), 16'h1110});
        get_word(w); check("R7 next word 6", {16'd0, w}, {16'd0, model(6)});

        // R7 wrap from last word to word 0
        send_cmd(3'b110, 6'd63);
        get_word(w); check("R7 word 63", {16'd0, w}, {16'd0, model(63)});
        get_word(w); check("R7 wrap to word 0", {16'd0, w}, {16'd0, model(0)});

        // R3 same-clock write mid-stream leaves data-out alone
        send_cmd(3'b110, 6'd10);
        pins(1'b1, 1'b0, 1'b0);
        rd(1'b0, v);
        check("R4 MSB after first fall", {31'd0, v[3]}, {31'd0, model(10)[15]});
        pins(1'b1, 1'b1, 1'b0);
        rd(1'b0, v);
        check("R3 no edge hold", v, {25'd0, 2'b11, 1'b0, model(10)[15], 3'b110});
        pins(1'b1, 1'b0, 1'b1);
        pins(1'b1, 1'b0, 1'b0);
        rd(1'b0, v);
        check("R4 second bit", {31'd0, v[3]}, {31'd0, model(10)[14]});

        // R5 deselected rising edge ends the read
        pins(1'b0, 1'b0, 1'b1);
        rd(1'b0, v); check("R5 clear on deselect", v, 32'h0000_0069);
        pins(1'b0, 1'b0, 1'b0);
        rd(1'b0, v); check("R5 stays idle", v, 32'h0000_0068);

        // R6 non-read opcode gives no data
        send_cmd(3'b101, 6'd3);
        get_word(w); check("R6 bad opcode idle", {16'd0, w}, 32'h0000_FFFF);

        // R8 R9 direct register, junk bits dropped
        wr(1'b1, 32'hFFFF_2AF1);
        rd(1'b1, v); check("R8 start clears", v, {model(42), 16'h2A10});
        wr(1'b1, 32'h0000_3E00);
        rd(1'b1, v); check("R8 word 62", v, {model(62), 16'h3E10});
        wr(1'b1, 32'h0000_4000);
        rd(1'b1, v); check("R9 addr 64 empty", v, 32'h0000_4010);
        wr(1'b1, 32'h0000_FF00);
        rd(1'b1, v); check("R9 addr 255 empty", v, 32'h0000_FF10);

        // R10 contents and checksum
        sum = '0;
        for (int i = 0; i < 64; i++) begin
            wr(1'b1, {16'd0, 8'(i), 8'd0});
            rd(1'b1, v);
            check("R10 word", {16'd0, v[31:16]}, {16'd0, model(i)});
            sum = sum + v[31:16];
        end
        check("R10 checksum", {16'd0, sum}, {16'd0, SUMT});

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule